// File: doc/BRIEF.md
# Matrix Keypad Row Scanner

This block reads a sixteen-key matrix keypad arranged as four rows by four columns. It raises one row line at a time, in a fixed rotation, and looks for a high level on the column lines while that row is raised. The column lines come straight from the keypad switches, so each one is passed through a two-stage synchronizer before any decision is made on it.

When a column reads high, the scanner records the key under the active row and that column. It turns the pair into a four-bit hexadecimal key code and raises a key-pressed flag. The scan then stays on that row until the recorded key's column drops low again. Other keys pressed in the meantime have no effect. Once the recorded key is released, the rotation resumes from the following row, so a keypad with several keys held down can never stall the scan.

The row moves forward once per scan tick. A parameterized divider produces the tick, and its period is long enough to cover the synchronizer delay before the columns are judged. Debouncing and any display of the code belong to blocks downstream.

Top module: `keypad_row_scanner`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, `rowDrive` is 4'b0001 (row 0), `keyValid` is 0 and `keyCode` is 4'h0.
- R2: While no key is held, `rowDrive` is one-hot (bit n high selects row n). It steps from row n to row (n+1) mod 4 exactly once every `TICK_DIV` clock cycles.
- R3: The key at row r (0 to 3) and column c (0 to 3) gives the following code, with columns listed from 0 to 3. Row 0 gives 1, 2, 3, A. Row 1 gives 4, 5, 6, B. Row 2 gives 7, 8, 9, C. Row 3 gives E, 0, F, D.
- R4: When a tick finds any synchronized column high, `keyValid` rises and `keyCode` takes that key's code on the same edge. While `keyValid` stays high, `rowDrive` and `keyCode` do not change.
- R5: If several columns are high on the row being scanned when a key is first detected, the lowest-numbered column is recorded.
- R6: While a key is recorded, pressing further keys in any row or column leaves `keyCode`, `keyValid` and `rowDrive` unchanged.
- R7: On the first tick that finds the recorded key's column low, `keyValid` falls and `rowDrive` moves on to the next row in rotation.
- R8: When the recorded key is released while other keys stay held, scanning resumes. The next held key reached in rotation order is then recorded, so the scan never locks up.
- R9: After release, `keyCode` keeps the last recorded code until a new key is recorded.
- R10: Each column input passes through two flip-flops before it is used. Because `TICK_DIV` is at least 3, a column change caused by a row step has settled before the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| colIn | input | 4 | Asynchronous column lines, high when a key on the driven row is closed |
| rowDrive | output | 4 | One-hot row drive, high selects the row |
| keyValid | output | 1 | High while a recorded key is held |
| keyCode | output | 4 | Hexadecimal code of the last recorded key |

## Verification
The assertions assume that the column lines respond only to the row currently being driven. They also assume that a key's contact, once made, stays closed until the stimulus releases it, so there are no bounce pulses shorter than a tick. The bench models the keypad as a set of held switches and derives `colIn` continuously from `rowDrive`. It changes that set only on falling clock edges, and it holds every press or release for several full scan ticks. This keeps every column change inside the synchronizer and tick timing that the scanner relies on.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

  localparam int KP_ROWS = 4;
  localparam int KP_COLS = 4;
  localparam int ROW_W   = $clog2(KP_ROWS);
  localparam int COL_W   = $clog2(KP_COLS);
  localparam int CODE_W  = 4;

  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_HOLD = 1'b1
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;  // step to the next row
    logic capture;  // record the key on the current row
  } scanCtrl_t;

  // row/column position to hexadecimal key value
  function automatic logic [CODE_W-1:0] keyDecode(input logic [ROW_W-1:0] row,
                                                  input logic [COL_W-1:0] col);
    logic [CODE_W-1:0] code;
    case ({row, col})
      4'h0: code = 4'h1;
      4'h1: code = 4'h2;
      4'h2: code = 4'h3;
      4'h3: code = 4'hA;
      4'h4: code = 4'h4;
      4'h5: code = 4'h5;
      4'h6: code = 4'h6;
      4'h7: code = 4'hB;
      4'h8: code = 4'h7;
      4'h9: code = 4'h8;
      4'hA: code = 4'h9;
      4'hB: code = 4'hC;
      4'hC: code = 4'hE;
      4'hD: code = 4'h0;
      4'hE: code = 4'hF;
      default: code = 4'hD;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/kpad_colsync.sv
module kpad_colsync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar i = 0; i < WIDTH; i++) begin : gSync
    logic stage1;
    logic stage2;
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end

endmodule

// File: rtl/kpad_datapath.sv
module kpad_datapath
  import kpad_pkg::*;
#(
  parameter int TICK_DIV = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [KP_COLS-1:0]  colIn,
  input  scanCtrl_t           ctrl,
  output logic                tick,
  output logic                anyCol,
  output logic                heldColHigh,
  output logic [KP_ROWS-1:0]  rowDrive,
  output logic [CODE_W-1:0]   keyCode
);

  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(KP_ROWS - 1);

  logic [KP_COLS-1:0] colSync;
  logic [CNT_W-1:0]   divCnt;
  logic [ROW_W-1:0]   rowIdx;
  logic [COL_W-1:0]   heldCol;
  logic [COL_W-1:0]   firstCol;

  kpad_colsync #(.WIDTH(KP_COLS)) uSync (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(colIn),
    .syncOut(colSync)
  );

  // scan tick divider
  always_ff @(posedge clk) begin
    if (rst || divCnt == CNT_LAST) divCnt <= '0;
    else                           divCnt <= divCnt + 1'b1;
  end
  assign tick = (divCnt == CNT_LAST);

  // active row
  always_ff @(posedge clk) begin
    if (rst)               rowIdx <= '0;
    else if (ctrl.advance) rowIdx <= (rowIdx == ROW_LAST) ? '0 : rowIdx + 1'b1;
  end

  for (genvar r = 0; r < KP_ROWS; r++) begin : gRow
    assign rowDrive[r] = (rowIdx == ROW_W'(r));
  end

  // lowest-numbered high column wins
  always_comb begin
    firstCol = '0;
    for (int c = KP_COLS - 1; c >= 0; c--) begin
      if (colSync[c]) firstCol = COL_W'(c);
    end
  end

  assign anyCol      = |colSync;
  assign heldColHigh = colSync[heldCol];

  always_ff @(posedge clk) begin
    if (rst) begin
      heldCol <= '0;
      keyCode <= '0;
    end else if (ctrl.capture) begin
      heldCol <= firstCol;
      keyCode <= keyDecode(rowIdx, firstCol);
    end
  end

endmodule

// File: rtl/kpad_ctrl.sv
module kpad_ctrl
  import kpad_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      anyCol,
  input  logic      heldColHigh,
  output scanCtrl_t ctrl,
  output logic      keyValid
);

  scanState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    ctrl.advance = 1'b0;
    ctrl.capture = 1'b0;
    unique case (state)
      ST_SCAN: begin
        if (tick) begin
          if (anyCol) begin
            ctrl.capture = 1'b1;
            stateNext    = ST_HOLD;
          end else begin
            ctrl.advance = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (tick && !heldColHigh) begin
          ctrl.advance = 1'b1;
          stateNext    = ST_SCAN;
        end
      end
      default: stateNext = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SCAN;
    else     state <= stateNext;
  end

  assign keyValid = (state == ST_HOLD);

endmodule

// File: rtl/keypad_row_scanner.sv
module keypad_row_scanner
  import kpad_pkg::*;
#(
  parameter int TICK_DIV = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] colIn,
  output logic [3:0] rowDrive,
  output logic       keyValid,
  output logic [3:0] keyCode
);

  scanCtrl_t ctrl;
  logic      tick;
  logic      anyCol;
  logic      heldColHigh;

  kpad_datapath #(.TICK_DIV(TICK_DIV)) uData (
    .clk        (clk),
    .rst        (rst),
    .colIn      (colIn),
    .ctrl       (ctrl),
    .tick       (tick),
    .anyCol     (anyCol),
    .heldColHigh(heldColHigh),
    .rowDrive   (rowDrive),
    .keyCode    (keyCode)
  );

  kpad_ctrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .anyCol     (anyCol),
    .heldColHigh(heldColHigh),
    .ctrl       (ctrl),
    .keyValid   (keyValid)
  );

endmodule

// File: rtl/kpad_checker.sv
module kpad_checker (
  input logic       clk,
  input logic       rst,
  input logic [3:0] rowDrive,
  input logic       keyValid,
  input logic [3:0] keyCode
);

  // R2: exactly one row driven at all times out of reset
  a_r2_onehot_row: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(rowDrive) == 1);

  // R2: a row change while scanning is a single rotation step
  a_r2_row_rotates: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !keyValid && !$past(keyValid) && rowDrive != $past(rowDrive))
      |-> rowDrive == {$past(rowDrive[2:0]), $past(rowDrive[3])});

  // R4: the row does not move on the detection edge
  a_r4_capture_row_kept: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(keyValid)) |-> $stable(rowDrive));

  // R4/R6: row and code frozen while a key is recorded
  a_r6_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && keyValid && $past(keyValid)) |-> ($stable(rowDrive) && $stable(keyCode)));

  // R7: release steps to the following row
  a_r7_release_advance: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(keyValid)) |-> rowDrive == {$past(rowDrive[2:0]), $past(rowDrive[3])});

  // R9: the code is kept through release and idle scanning
  a_r9_code_kept: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !keyValid) |-> $stable(keyCode));

endmodule

bind keypad_row_scanner kpad_checker uChk (
  .clk     (clk),
  .rst     (rst),
  .rowDrive(rowDrive),
  .keyValid(keyValid),
  .keyCode (keyCode)
);

// File: tb/sim_keypad_row_scanner.sv
module sim_keypad_row_scanner;

  localparam int TICK = 16;
  localparam int WAIT_LIMIT = 12 * TICK;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  colIn;
  logic [3:0]  rowDrive;
  logic        keyValid;
  logic [3:0]  keyCode;
  logic [15:0] keysDown = '0;  // bit r*4+c = key at row r, column c held

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  // keypad model: a column is high when a held key sits on a driven row
  for (genvar c = 0; c < 4; c++) begin : gPad
    assign colIn[c] = (rowDrive[0] & keysDown[c])     | (rowDrive[1] & keysDown[4 + c]) |
                      (rowDrive[2] & keysDown[8 + c]) | (rowDrive[3] & keysDown[12 + c]);
  end

  keypad_row_scanner #(.TICK_DIV(TICK)) u0 (
    .clk     (clk),
    .rst     (rst),
    .colIn   (colIn),
    .rowDrive(rowDrive),
    .keyValid(keyValid),
    .keyCode (keyCode)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expCode(input int r, input int c);
    logic [3:0] t [16] = '{4'h1, 4'h2, 4'h3, 4'hA, 4'h4, 4'h5, 4'h6, 4'hB,
                           4'h7, 4'h8, 4'h9, 4'hC, 4'hE, 4'h0, 4'hF, 4'hD};
    return t[r * 4 + c];
  endfunction

  task automatic waitValid(input logic level);
    for (int i = 0; i < WAIT_LIMIT; i++) begin
      if (keyValid === level) break;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(rowDrive === 4'b0001, "R1 rowDrive", rowDrive, 4'b0001);
    check(keyValid === 1'b0, "R1 keyValid", keyValid, 0);
    check(keyCode === 4'h0, "R1 keyCode", keyCode, 0);
  endtask

  task automatic testRotation();
    logic [3:0] prev;
    prev = rowDrive;
    while (rowDrive === prev) @(negedge clk);  // align to a step
    for (int s = 0; s < 6; s++) begin
      int n;
      prev = rowDrive;
      n = 0;
      while (rowDrive === prev && n < 4 * TICK) begin
        @(negedge clk);
        n++;
      end
      check(n == TICK, "R2 step period", n, TICK);
      check(rowDrive === {prev[2:0], prev[3]}, "R2 rotation", rowDrive, {prev[2:0], prev[3]});
    end
  endtask

  task automatic testKey(input int r, input int c);
    logic [3:0] code;
    code = expCode(r, c);
    keysDown[r * 4 + c] = 1'b1;
    waitValid(1'b1);
    check(keyValid === 1'b1, "R4 detect", keyValid, 1);
    check(keyCode === code, "R3 key map", keyCode, code);
    check(rowDrive === 4'(1 << r), "R4 row at capture", rowDrive, 4'(1 << r));
    repeat (3 * TICK) @(negedge clk);
    check(keyValid === 1'b1 && rowDrive === 4'(1 << r), "R4 held frozen",
          {keyValid, rowDrive}, {1'b1, 4'(1 << r)});
    keysDown = '0;
    waitValid(1'b0);
    check(rowDrive === 4'(1 << ((r + 1) % 4)), "R7 resume next row", rowDrive,
          4'(1 << ((r + 1) % 4)));
    check(keyCode === code, "R9 code kept", keyCode, code);
  endtask

  task automatic testLowestCol();
    keysDown[8 + 3] = 1'b1;
    keysDown[8 + 1] = 1'b1;
    keysDown[8 + 2] = 1'b1;
    waitValid(1'b1);
    check(keyCode === 4'h8, "R5 lowest column", keyCode, 4'h8);
    keysDown = '0;
    waitValid(1'b0);
    check(keyValid === 1'b0, "R5 release", keyValid, 0);
  endtask

  task automatic testIgnoreAndNoLock();
    keysDown[0] = 1'b1;  // row 0 col 0 -> 1
    waitValid(1'b1);
    check(keyCode === 4'h1, "R6 first key", keyCode, 4'h1);
    keysDown[15] = 1'b1;  // row 3 col 3
    keysDown[2]  = 1'b1;  // row 0 col 2
    keysDown[5]  = 1'b0;
    repeat (5 * 4 * TICK) @(negedge clk);
    check(keyValid === 1'b1 && keyCode === 4'h1 && rowDrive === 4'b0001, "R6 others ignored",
          {keyValid, keyCode, rowDrive}, {1'b1, 4'h1, 4'b0001});
    keysDown[0] = 1'b0;
    waitValid(1'b0);
    check(keyValid === 1'b0, "R8 release with others held", keyValid, 0);
    waitValid(1'b1);
    check(keyValid === 1'b1 && keyCode === 4'hD, "R8 next held key", {keyValid, keyCode},
          {1'b1, 4'hD});
    keysDown = '0;
    waitValid(1'b0);
    check(keyValid === 1'b0, "R8 final release", keyValid, 0);
  endtask

  task automatic testSyncSettle();
    // R10: a key pressed mid-scan is seen on the first tick of its row
    keysDown[4 + 2] = 1'b1;  // row 1 col 2 -> 6
    while (rowDrive !== 4'b0010) @(negedge clk);
    keysDown[4 + 2] = 1'b1;
    for (int i = 0; i < TICK + 1; i++) begin
      if (keyValid === 1'b1) break;
      @(negedge clk);
    end
    check(keyValid === 1'b1 && keyCode === 4'h6, "R10 settled within one tick",
          {keyValid, keyCode}, {1'b1, 4'h6});
    keysDown = '0;
    waitValid(1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    testReset();
    testRotation();
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) testKey(r, c);
    end
    testLowestCol();
    testIgnoreAndNoLock();
    testSyncSettle();
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule